// File: doc/BRIEF.md
# Emulated-Instruction Dispatch and Skip Unit

This block sits beside a microcoded datapath that emulates a 16-bit, four-accumulator minicomputer instruction set. It captures the emulated instruction word from the processor bus into an instruction register. It then turns fields of that word into a small next-address modifier, which microcode ORs into its branch target to reach the right handler. It also evaluates the carry and skip outcome of the emulated arithmetic-logic instructions, using the shifter result and the ALU carry that the datapath supplies.

One 3-bit operation code selects the work done in a clocked step. The codes are: load the instruction register; dispatch on the instruction class; dispatch on the accumulator-source class; evaluate carry and skip; or idle. A step happens only on a rising clock edge while the enable input is high. The modifier, skip flag and carry flag are all registered, so their values appear one cycle after the step that produced them.

Bits of the instruction word are numbered with bit 0 as the most significant bit, so bit k sits at vector index 15−k.

Top module: `emu_dispatch_skip`

## Requirements
- R1: On a clock edge with `rst_n` low, the instruction register, `nmod`, `skip` and `carry` all become 0.
- R2: On an edge where `en` is low, `nmod`, `skip`, `carry` and the instruction register keep their values whatever `op` and the data inputs are.
- R3: Operation code 1 (load) copies `bus_in` into the instruction register and clears `skip`. It sets `nmod` to 8·bit0 plus bits 5–7 read as a 3-bit number, taken from the loaded word.
- R4: Operation code 2 (class dispatch) depends on the opcode field, bits 1–2. The field value 1 gives `nmod` = 4 and the value 2 gives `nmod` = 5. The value 0 gives the function field, bits 3–4.
- R5: Under operation code 2 with bits 1–2 = 3, `nmod` is bits 4–7 with four values remapped: 0 and 1 swap, and 6 and 14 swap.
- R6: Operation code 3 (accumulator-source dispatch) with bit 0 set gives `nmod` = 3 minus the shift field, bits 8–9.
- R7: Operation code 3 with bit 0 clear and bits 1–2 not equal to 3 gives `nmod` = bit 5.
- R8: Operation code 3 with bit 0 clear and bits 1–2 = 3 maps bits 3–7 to `nmod` as follows: 0→2, 1→5, 2→3, 3→6, 4→7, 9→4, 10→4, 14→1, 31→15, and every other value →14.
- R9: Operation code 4 (evaluate) forms a carry-in from `carry` XOR a term chosen by bits 10–11. The term is `alu_cy` for 0, 0 for 1, 1 for 2, and NOT `alu_cy` for 3. When bit 12 is 0, this carry-in is stored into `carry`. The step also sets `nmod` to 0.
- R10: Under operation code 4 with bit 12 = 1, `carry` keeps its value.
- R11: Operation code 4 sets `skip` to bit 15 XOR a condition chosen by bits 13–14. The condition is 0 for 0, NOT carry-in for 1, (`shift_in` = 0) for 2, and (`shift_in` = 0) OR NOT carry-in for 3.
- R12: Operation codes 0, 5, 6 and 7 set `nmod` to 0. The codes other than 1 and 4 leave `skip` and `carry` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Step enable |
| op | input | 3 | Operation code for this step |
| bus_in | input | 16 | Processor bus, source of the instruction word |
| shift_in | input | 16 | Shifter result used by the zero test |
| alu_cy | input | 1 | ALU carry out |
| nmod | output | 4 | Registered next-address modifier |
| skip | output | 1 | Registered skip flag |
| carry | output | 1 | Registered emulated carry flag |

## Verification
The assertions watch several rules on every cycle. A disabled step changes nothing. A load clears `skip` and derives `nmod` from the bus word. The no-load bit freezes `carry`. Idle and unlisted codes zero `nmod`, and the codes other than load and evaluate keep both flags. The exact decode tables can only be shown by the bench's directed scenarios. These cover the adrp swaps, the accumulator-source remapping over all 32 values and the carry-in and skip-condition combinations. The bench also reads back a word that was ignored under a low enable, by dispatching on it afterwards.

// File: rtl/emu_dispatch_pkg.sv
// Package: shared operation codes and instruction-field positions for the
// emulated-instruction dispatch unit. Field bit k (MSB = 0) sits at index 15-k.
package emu_dispatch_pkg;

    localparam int WORD_W = 16;
    localparam int MOD_W  = 4;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_CLASS = 3'd2,
        OP_ACSRC = 3'd3,
        OP_EVAL  = 3'd4
    } step_op_e;

    // vector indices of single-bit fields
    localparam int B_TOP    = 15;  // bit 0
    localparam int B_IND    = 10;  // bit 5
    localparam int B_NOLOAD = 3;   // bit 12
    localparam int B_INVERT = 0;   // bit 15

endpackage

// File: rtl/emu_class_decode.sv
// Module: emu_class_decode
// Purpose: pure combinational decode of a held instruction word into the two
// dispatch modifiers (class dispatch and accumulator-source dispatch).
// Assumes: word uses MSB = 0 bit numbering; outputs are registered by the parent.
module emu_class_decode
    import emu_dispatch_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [MOD_W-1:0]  class_mod,
    output logic [MOD_W-1:0]  acsrc_mod
);

    logic [1:0] opc;
    logic [1:0] fn;
    logic [3:0] adr;
    logic [4:0] ext;
    logic [1:0] shf;
    logic       unused_lo;

    assign opc = word[14:13];
    assign fn  = word[12:11];
    assign adr = word[11:8];
    assign ext = word[12:8];
    assign shf = word[7:6];
    assign unused_lo = ^word[5:0];

    // class dispatch: opcode field, with the addressing group remapped
    always_comb begin
        unique case (opc)
            2'd1:    class_mod = 4'd4;
            2'd2:    class_mod = 4'd5;
            2'd3: begin
                unique case (adr)
                    4'd0:    class_mod = 4'd1;
                    4'd1:    class_mod = 4'd0;
                    4'd6:    class_mod = 4'd14;
                    4'd14:   class_mod = 4'd6;
                    default: class_mod = adr;
                endcase
            end
            default: class_mod = {2'b00, fn};
        endcase
    end

    // accumulator-source dispatch: shift group, indirect bit or extended-op table
    always_comb begin
        if (word[B_TOP]) begin
            acsrc_mod = {2'b00, 2'd3 - shf};
        end else if (opc != 2'd3) begin
            acsrc_mod = {3'b000, word[B_IND]};
        end else begin
            unique case (ext)
                5'd0:    acsrc_mod = 4'd2;
                5'd1:    acsrc_mod = 4'd5;
                5'd2:    acsrc_mod = 4'd3;
                5'd3:    acsrc_mod = 4'd6;
                5'd4:    acsrc_mod = 4'd7;
                5'd9:    acsrc_mod = 4'd4;
                5'd10:   acsrc_mod = 4'd4;
                5'd14:   acsrc_mod = 4'd1;
                5'd31:   acsrc_mod = 4'd15;
                default: acsrc_mod = 4'd14;
            endcase
        end
    end

endmodule

// File: rtl/emu_carry_skip.sv
// Module: emu_carry_skip
// Purpose: combinational carry-in and skip evaluation for an emulated
// arithmetic-logic instruction, from its low six bits.
// Assumes: flags_in is the currently stored carry; result is captured by parent.
module emu_carry_skip
    import emu_dispatch_pkg::*;
(
    input  logic [5:0]        lo_bits,   // word bits 10..15
    input  logic              carry_q,
    input  logic              alu_cy,
    input  logic [WORD_W-1:0] shift_val,
    output logic              cy_in,
    output logic              skip_val,
    output logic              cy_store
);

    logic [1:0] cy_sel;
    logic [1:0] cond_sel;
    logic       sh_zero;
    logic       base_cy;
    logic       cond;

    assign cy_sel   = lo_bits[5:4];
    assign cond_sel = lo_bits[2:1];
    assign sh_zero  = (shift_val == '0);
    assign cy_store = ~lo_bits[B_NOLOAD];

    // carry-in base term chosen by the carry field
    always_comb begin
        unique case (cy_sel)
            2'd1:    base_cy = 1'b0;
            2'd2:    base_cy = 1'b1;
            2'd3:    base_cy = ~alu_cy;
            default: base_cy = alu_cy;
        endcase
    end

    assign cy_in = carry_q ^ base_cy;

    // skip condition chosen by the condition field
    always_comb begin
        unique case (cond_sel)
            2'd1:    cond = ~cy_in;
            2'd2:    cond = sh_zero;
            2'd3:    cond = sh_zero | ~cy_in;
            default: cond = 1'b0;
        endcase
    end

    assign skip_val = cond ^ lo_bits[B_INVERT];

endmodule

// File: rtl/emu_dispatch_skip.sv
// Module: emu_dispatch_skip (top)
// Purpose: instruction register plus registered dispatch modifier, skip and
// carry flags for microcoded emulation of a 16-bit instruction set.
// Assumes: one step per enabled rising edge; synchronous active-low reset.
module emu_dispatch_skip
    import emu_dispatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] shift_in,
    input  logic              alu_cy,
    output logic [MOD_W-1:0]  nmod,
    output logic              skip,
    output logic              carry
);

    logic [WORD_W-1:0] ir_q;
    logic [MOD_W-1:0]  class_mod;
    logic [MOD_W-1:0]  acsrc_mod;
    logic [MOD_W-1:0]  load_mod;
    logic              cy_in;
    logic              skip_val;
    logic              cy_store;

    emu_class_decode u_decode (
        .word      (ir_q),
        .class_mod (class_mod),
        .acsrc_mod (acsrc_mod)
    );

    emu_carry_skip u_cs (
        .lo_bits   (ir_q[5:0]),
        .carry_q   (carry),
        .alu_cy    (alu_cy),
        .shift_val (shift_in),
        .cy_in     (cy_in),
        .skip_val  (skip_val),
        .cy_store  (cy_store)
    );

    // modifier produced by a load, taken from the incoming word
    assign load_mod = {bus_in[B_TOP], bus_in[10:8]};

    // state update: one operation per enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            nmod  <= '0;
            skip  <= 1'b0;
            carry <= 1'b0;
        end else if (en) begin
            unique case (op)
                OP_LOAD: begin
                    ir_q <= bus_in;
                    skip <= 1'b0;
                    nmod <= load_mod;
                end
                OP_CLASS: nmod <= class_mod;
                OP_ACSRC: nmod <= acsrc_mod;
                OP_EVAL: begin
                    nmod <= '0;
                    skip <= skip_val;
                    if (cy_store) carry <= cy_in;
                end
                default: nmod <= '0;
            endcase
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(nmod) && $stable(skip) && $stable(carry) && $stable(ir_q)));

    // R3
    load_clears_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_LOAD) |=> !skip);

    // R3
    load_mod_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_LOAD) |=> (nmod == {$past(bus_in[15]), $past(bus_in[10:8])}));

    // R10
    noload_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_EVAL && ir_q[B_NOLOAD]) |=> $stable(carry));

    // R12
    unlisted_mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == OP_IDLE || op > OP_EVAL)) |=> (nmod == '0));

    // R12
    flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != OP_LOAD && op != OP_EVAL) |=> ($stable(skip) && $stable(carry)));

    // R4
    class_small_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_CLASS && ir_q[14:13] != 2'd3) |=> (nmod <= 4'd5));

endmodule

// File: tb/test_emu_dispatch_skip.sv
module test_emu_dispatch_skip;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] bus_in = '0;
    logic [15:0] shift_in = '0;
    logic        alu_cy = 1'b0;
    logic [3:0]  nmod;
    logic        skip;
    logic        carry;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    emu_dispatch_skip i_emu_dispatch_skip (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .bus_in(bus_in),
        .shift_in(shift_in), .alu_cy(alu_cy), .nmod(nmod), .skip(skip), .carry(carry)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one step at a falling edge, return at the next falling edge
    task automatic step(input logic e, input logic [2:0] o, input logic [15:0] b,
                        input logic [15:0] s, input logic c);
        @(negedge clk);
        en = e; op = o; bus_in = b; shift_in = s; alu_cy = c;
        @(negedge clk);
        en = 1'b0;
    endtask

    // word with bit0, opcode, function, indirect, index, shift, carry, noload, cond, invert
    function automatic logic [15:0] mk(input logic b0, input logic [1:0] opc,
        input logic [1:0] fn, input logic ind, input logic [1:0] idx,
        input logic [1:0] shf, input logic [1:0] cf, input logic nl,
        input logic [1:0] sc, input logic inv);
        return {b0, opc, fn, ind, idx, shf, cf, nl, sc, inv};
    endfunction

    task automatic t_reset();
        chk("R1 nmod", nmod, 0); chk("R1 skip", skip, 0); chk("R1 carry", carry, 0);
        step(1, 3'd2, 16'h0, 16'h0, 0);
        chk("R1 ir zero via class dispatch", nmod, 0);
    endtask

    task automatic t_load();
        step(1, 3'd1, mk(1,0,0,1,2'd2,0,0,0,0,0), 16'h0, 0);
        chk("R3 load mod 14", nmod, 14);
        step(1, 3'd1, mk(0,2,3,0,2'd3,0,0,0,0,0), 16'h0, 0);
        chk("R3 load mod 3", nmod, 3);
        // force skip to 1, then a load must clear it
        step(1, 3'd1, mk(0,0,0,0,0,0,0,1,2'd0,1), 16'h0, 0);
        step(1, 3'd4, 16'h0, 16'h0, 0);
        chk("R11 invert with cond 0", skip, 1);
        step(1, 3'd1, 16'h0, 16'h0, 0);
        chk("R3 load clears skip", skip, 0);
    endtask

    task automatic t_class();
        step(1, 3'd1, mk(0,1,3,0,0,0,0,0,0,0), 16'h0, 0);
        step(1, 3'd2, 16'h0, 16'h0, 0); chk("R4 opc1", nmod, 4);
        step(1, 3'd1, mk(0,2,1,0,0,0,0,0,0,0), 16'h0, 0);
        step(1, 3'd2, 16'h0, 16'h0, 0); chk("R4 opc2", nmod, 5);
        step(1, 3'd1, mk(0,0,2,0,0,0,0,0,0,0), 16'h0, 0);
        step(1, 3'd2, 16'h0, 16'h0, 0); chk("R4 opc0 fn2", nmod, 2);
        step(1, 3'd1, mk(0,0,3,1,3,0,0,0,0,0), 16'h0, 0);
        step(1, 3'd2, 16'h0, 16'h0, 0); chk("R4 opc0 fn3", nmod, 3);
        for (int a = 0; a < 16; a++) begin
            int e;
            e = (a == 0) ? 1 : (a == 1) ? 0 : (a == 6) ? 14 : (a == 14) ? 6 : a;
            step(1, 3'd1, {1'b0, 2'b11, 1'b0, 4'(a), 8'h00}, 16'h0, 0);
            step(1, 3'd2, 16'h0, 16'h0, 0);
            chk($sformatf("R5 adrp %0d", a), nmod, e);
        end
    endtask

    task automatic t_acsrc();
        for (int s = 0; s < 4; s++) begin
            step(1, 3'd1, mk(1,3,0,1,0,2'(s),0,0,0,0), 16'h0, 0);
            step(1, 3'd3, 16'h0, 16'h0, 0);
            chk($sformatf("R6 shift %0d", s), nmod, 3 - s);
        end
        for (int o = 0; o < 3; o++) begin
            step(1, 3'd1, mk(0,2'(o),3,1,3,3,0,0,0,0), 16'h0, 0);
            step(1, 3'd3, 16'h0, 16'h0, 0);
            chk($sformatf("R7 opc %0d ind 1", o), nmod, 1);
            step(1, 3'd1, mk(0,2'(o),3,0,3,3,0,0,0,0), 16'h0, 0);
            step(1, 3'd3, 16'h0, 16'h0, 0);
            chk($sformatf("R7 opc %0d ind 0", o), nmod, 0);
        end
        for (int x = 0; x < 32; x++) begin
            int e;
            case (x)
                0: e = 2;  1: e = 5;  2: e = 3;  3: e = 6;  4: e = 7;
                9: e = 4;  10: e = 4; 14: e = 1; 31: e = 15;
                default: e = 14;
            endcase
            step(1, 3'd1, {1'b0, 2'b11, 5'(x), 8'hFF}, 16'h0, 0);
            step(1, 3'd3, 16'h0, 16'h0, 0);
            chk($sformatf("R8 opx %0d", x), nmod, e);
        end
    endtask

    // load a word, then evaluate it with the given shifter value and ALU carry
    task automatic evalw(input logic [15:0] w, input logic [15:0] s, input logic c,
                         input string req, input int exp_cy, input int exp_sk);
        step(1, 3'd1, w, 16'h0, 0);
        step(1, 3'd4, 16'hFFFF, s, c);
        chk({req, " carry"}, carry, exp_cy);
        chk({req, " skip"}, skip, exp_sk);
        chk({req, " nmod"}, nmod, 0);
    endtask

    task automatic t_carry();
        // stored carry starts at 0 here
        evalw(mk(0,0,0,0,0,0,2'd2,0,0,0), 16'h1, 0, "R9 cf2", 1, 0);
        evalw(mk(0,0,0,0,0,0,2'd0,0,0,0), 16'h1, 1, "R9 cf0 cy1", 0, 0);
        evalw(mk(0,0,0,0,0,0,2'd3,0,0,0), 16'h1, 0, "R9 cf3 cy0", 1, 0);
        evalw(mk(0,0,0,0,0,0,2'd1,0,0,0), 16'h1, 1, "R9 cf1", 1, 0);
        evalw(mk(0,0,0,0,0,0,2'd3,0,0,0), 16'h1, 1, "R9 cf3 cy1", 1, 0);
        evalw(mk(0,0,0,0,0,0,2'd2,0,0,0), 16'h1, 0, "R9 cf2 toggle", 0, 0);
        evalw(mk(0,0,0,0,0,0,2'd2,1,2'd1,0), 16'h1, 0, "R10 noload", 0, 0);
        evalw(mk(0,0,0,0,0,0,2'd2,1,2'd1,1), 16'h1, 0, "R10 noload inv", 0, 1);
    endtask

    task automatic t_skip();
        // carry stays 0 throughout (noload set)
        evalw(mk(0,0,0,0,0,0,0,1,2'd1,0), 16'h5, 0, "R11 notcy", 0, 1);
        evalw(mk(0,0,0,0,0,0,0,1,2'd1,1), 16'h5, 0, "R11 notcy inv", 0, 0);
        evalw(mk(0,0,0,0,0,0,0,1,2'd2,0), 16'h0, 0, "R11 zero", 0, 1);
        evalw(mk(0,0,0,0,0,0,0,1,2'd2,0), 16'h5, 0, "R11 nonzero", 0, 0);
        evalw(mk(0,0,0,0,0,0,0,1,2'd2,1), 16'h5, 0, "R11 nonzero inv", 0, 1);
        evalw(mk(0,0,0,0,0,0,2'd2,1,2'd3,0), 16'h5, 0, "R11 or both false", 0, 0);
        evalw(mk(0,0,0,0,0,0,0,1,2'd3,0), 16'h5, 0, "R11 or notcy", 0, 1);
        evalw(mk(0,0,0,0,0,0,2'd2,1,2'd3,0), 16'h0, 0, "R11 or zero", 0, 1);
    endtask

    task automatic t_enable_and_idle();
        // set a known state: carry 1, skip 1, IR with opc1
        evalw(mk(0,0,0,0,0,0,2'd2,0,2'd1,1), 16'h1, 0, "R9 setup", 1, 1);
        step(1, 3'd1, mk(0,1,0,0,0,0,0,0,0,0), 16'h0, 0);   // nmod 0, skip 0
        step(1, 3'd2, 16'h0, 16'h0, 0);                     // nmod 4
        step(0, 3'd1, mk(1,2,0,1,3,0,0,0,0,0), 16'h0, 0);
        chk("R2 nmod held", nmod, 4); chk("R2 skip held", skip, 0); chk("R2 carry held", carry, 1);
        step(0, 3'd4, 16'h0, 16'h0, 1);
        chk("R2 eval ignored carry", carry, 1);
        step(1, 3'd2, 16'h0, 16'h0, 0);
        chk("R2 ir unchanged", nmod, 4);
        for (int o = 5; o < 9; o++) begin
            step(1, 3'(o), 16'hFFFF, 16'h0, 1);
            chk($sformatf("R12 op %0d nmod", o % 8), nmod, 0);
            chk($sformatf("R12 op %0d carry", o % 8), carry, 1);
            chk($sformatf("R12 op %0d skip", o % 8), skip, 0);
            step(1, 3'd2, 16'h0, 16'h0, 0);
        end
        step(1, 3'd3, 16'h0, 16'h0, 0);
        chk("R12 dispatch keeps carry", carry, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_class();
        t_acsrc();
        t_carry();
        t_skip();
        t_enable_and_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule